// File: doc/BRIEF.md
# Radio packet framer and symbol encoder

This block turns a buffered packet into the serial bit stream for a half-duplex radio transmitter. On a start strobe it reads the packet through a byte read port. The first byte is the control byte, and its low six bits give the packet length. The block then sends, in order:

- an optional extended wake-up preamble;
- a square-wave preamble;
- a frame-sync byte;
- one DC-balanced 12-bit symbol per packet byte;
- a final symbol that carries an 8-bit checksum.

A bit-period counter paces every bit from the system clock. With the default of 128 clocks per bit, a 20.48 MHz clock gives 160 kbit/s.

The transmitter enable output is active low. It is asserted for exactly the length of the frame. The serial data line is held low whenever the enable is inactive.

The extended wake-up preamble is made of wake-up units. Each unit is a fixed run of preamble cycles followed by a hold code. The hold code keeps a sleeping remote receiver locked until the real packet follows.

Top module: `rpkt_framer`

## Requirements
- R1: After reset, and after every frame ends, `busy_o` is 0, `tx_en_n_o` is 1 and `txd_o` is 0. `txd_o` is 0 in every cycle in which `tx_en_n_o` is 1.
- R2: `start_i` is accepted only when `busy_o` is 0. From the clock edge that accepts it, `busy_o` is 1 and `tx_en_n_o` is 0 until the last checksum bit has lasted its full period. A `start_i` pulse while busy has no effect on the frame.
- R3: Every transmitted bit lasts exactly CLK_PER_BIT clock cycles, and `txd_o` changes only at bit boundaries.
- R4: The normal preamble is `pre_cycles_i` repetitions of the pair 0 then 1. A value of 0 is treated as 1, so the first bit of every frame is 0.
- R5: After the preamble the frame-sync byte 11100100 is sent MSB first. This is the 7-bit Barker code 1110010 plus a 0 balancing bit.
- R6: Each byte b is sent MSB first as the 12-bit symbol {C(b[7:4]), C(b[3:0])}. C(k) is the k-th value, counting from 0, in the ascending list of 6-bit words with exactly three ones, leaving out 000111 and 111000. Every symbol therefore has six ones, no run longer than four, and a Hamming distance of at least 2 to every other symbol.
- R7: The packet length is the control byte's bits [5:0], with 0 sent as 1 byte and values above MAX_BYTES sent as MAX_BYTES bytes. Bytes are read from buffer address 0 upward, and `rd_addr_o` stays below MAX_BYTES.
- R8: After the data symbols, one symbol carries the modulo-256 sum of all sent packet bytes, including the control byte.
- R9: A nonzero `wake_units_i` puts that many wake-up units before the normal preamble. Each unit is HOLD_SPAN preamble pairs followed by the hold code 00011011, which is the complemented Barker code plus a 1 balancing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that starts a frame |
| pre_cycles_i | input | 8 | Preamble length in 0/1 pairs, sampled at start |
| wake_units_i | input | 8 | Number of wake-up units, 0 for none, sampled at start |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, read combinationally from the packet buffer |
| rd_addr_o | output | $clog2(MAX_BYTES) | Packet buffer read address |
| busy_o | output | 1 | High while a frame is in progress |
| tx_en_n_o | output | 1 | Transmitter enable, active low |
| txd_o | output | 1 | Serial transmit data |

## Verification
Some properties are timing rules, and the bound checker tests them on every cycle:

- data is low while the transmitter is disabled;
- the data line never moves inside a bit period;
- frames begin with a 0 and end on a bit boundary;
- a strobe in idle always raises busy;
- the read address stays in range.

The content of the frame can only be shown by the bench's scenarios. The bench captures each bit at mid-period and compares it against a frame built from the requirements. This covers the preamble and wake-up layout, the sync and hold codes, the symbol mapping of all 256 byte values, the length clamping and the checksum. It also shows that a strobe during a frame leaves the stream untouched.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_HOLD,
        ST_PRE,
        ST_SYNC,
        ST_DATA,
        ST_CSUM
    } fr_state_e;

    // Barker 1110010 + balancing 0, and its complement + balancing 1
    localparam logic [7:0] SYNC_WORD = 8'b1110_0100;
    localparam logic [7:0] HOLD_WORD = 8'b0001_1011;

    // k-th ascending 6-bit word with three ones, skipping 000111 and 111000
    function automatic logic [5:0] nib_code(input int k);
        int         seen;
        logic [5:0] r;
        seen = 0;
        r    = '0;
        for (int v = 0; v < 64; v++) begin
            if ($countones(6'(v)) == 3 && v != 7 && v != 56) begin
                if (seen == k) r = 6'(v);
                seen++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rpf_bit_timer.sv
module rpf_bit_timer #(
    parameter int CLK_PER_BIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int TW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == TW'(CLK_PER_BIT - 1));
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rpf_sym_enc.sv
module rpf_sym_enc
    import rpf_pkg::*;
(
    input  logic [7:0]  byte_i,
    output logic [11:0] sym_o
);
    logic [5:0] tab [16];

    for (genvar g = 0; g < 16; g++) begin : g_tab
        localparam logic [5:0] CODE = nib_code(g);
        assign tab[g] = CODE;
    end

    assign sym_o = {tab[byte_i[7:4]], tab[byte_i[3:0]]};
endmodule

// File: rtl/rpkt_framer.sv
module rpkt_framer
    import rpf_pkg::*;
#(
    parameter int CLK_PER_BIT = 128,
    parameter int MAX_BYTES   = 60,
    parameter int HOLD_SPAN   = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [7:0]                   pre_cycles_i,
    input  logic [7:0]                   wake_units_i,
    input  logic [7:0]                   rd_data_i,
    output logic [$clog2(MAX_BYTES)-1:0] rd_addr_o,
    output logic                         busy_o,
    output logic                         tx_en_n_o,
    output logic                         txd_o
);
    localparam int AW  = $clog2(MAX_BYTES);
    localparam int LW  = $clog2(MAX_BYTES + 1);
    localparam int HCW = $clog2(HOLD_SPAN + 1);
    localparam int CW  = (HCW > 8) ? HCW : 8;

    typedef struct packed {
        fr_state_e      st;
        logic           busy;
        logic [11:0]    sh;     // left-aligned word being sent
        logic [3:0]     nb;     // bits left in word, including current
        logic [CW-1:0]  cyc;    // preamble pairs left, including current
        logic [7:0]     units;
        logic [7:0]     pre;
        logic [AW-1:0]  idx;
        logic [LW-1:0]  left;   // data bytes still to load
        logic [7:0]     csum;
    } fr_regs_t;

    fr_regs_t d, q;

    logic        tick;
    logic        take;
    logic [7:0]  enc_in;
    logic [11:0] enc_sym;
    logic [7:0]  pre_eff;
    logic [5:0]  ctl_len;
    logic [LW-1:0] n_bytes;

    assign take = (q.st == ST_IDLE) && start_i;

    rpf_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (take),
        .tick_o (tick)
    );

    assign enc_in = (q.st == ST_DATA && q.left == '0) ? q.csum : rd_data_i;

    rpf_sym_enc u_enc (
        .byte_i (enc_in),
        .sym_o  (enc_sym)
    );

    always_comb begin
        pre_eff = (pre_cycles_i == 8'd0) ? 8'd1 : pre_cycles_i;
        ctl_len = rd_data_i[5:0];
        if (ctl_len == 6'd0)                n_bytes = LW'(1);
        else if (int'(ctl_len) > MAX_BYTES) n_bytes = LW'(MAX_BYTES);
        else                                n_bytes = LW'(ctl_len);
    end

    always_comb begin
        d = q;
        if (q.st == ST_IDLE) begin
            if (start_i) begin
                d.busy  = 1'b1;
                d.pre   = pre_eff;
                d.units = wake_units_i;
                d.csum  = '0;
                d.idx   = '0;
                d.left  = n_bytes;
                d.sh    = {2'b01, 10'b0};
                d.nb    = 4'd2;
                if (wake_units_i != 8'd0) begin
                    d.st  = ST_WAKE;
                    d.cyc = CW'(HOLD_SPAN);
                end else begin
                    d.st  = ST_PRE;
                    d.cyc = CW'(pre_eff);
                end
            end
        end else if (tick) begin
            if (q.nb != 4'd1) begin
                d.sh = q.sh << 1;
                d.nb = q.nb - 4'd1;
            end else begin
                case (q.st)
                    ST_WAKE, ST_PRE: begin
                        if (q.cyc != CW'(1)) begin
                            d.cyc = q.cyc - CW'(1);
                            d.sh  = {2'b01, 10'b0};
                            d.nb  = 4'd2;
                        end else begin
                            d.st = (q.st == ST_WAKE) ? ST_HOLD : ST_SYNC;
                            d.sh = {(q.st == ST_WAKE) ? HOLD_WORD : SYNC_WORD, 4'b0};
                            d.nb = 4'd8;
                        end
                    end
                    ST_HOLD: begin
                        d.units = q.units - 8'd1;
                        d.sh    = {2'b01, 10'b0};
                        d.nb    = 4'd2;
                        if (q.units != 8'd1) begin
                            d.st  = ST_WAKE;
                            d.cyc = CW'(HOLD_SPAN);
                        end else begin
                            d.st  = ST_PRE;
                            d.cyc = CW'(q.pre);
                        end
                    end
                    ST_SYNC, ST_DATA: begin
                        d.sh = enc_sym;
                        d.nb = 4'd12;
                        if (q.st == ST_SYNC || q.left != '0) begin
                            d.st   = ST_DATA;
                            d.csum = q.csum + rd_data_i;
                            d.left = q.left - LW'(1);
                            d.idx  = (q.left == LW'(1)) ? '0 : q.idx + AW'(1);
                        end else begin
                            d.st = ST_CSUM;
                        end
                    end
                    ST_CSUM: begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.sh   = '0;
                        d.nb   = '0;
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr_o = q.idx;
    assign busy_o    = q.busy;
    assign tx_en_n_o = ~q.busy;
    assign txd_o     = q.sh[11];
endmodule

// File: rtl/rpf_checker.sv
module rpf_checker #(
    parameter int CLK_PER_BIT = 128,
    parameter int MAX_BYTES   = 60
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start_i,
    input logic [$clog2(MAX_BYTES)-1:0] rd_addr_o,
    input logic                         busy_o,
    input logic                         tx_en_n_o,
    input logic                         txd_o
);
    localparam int PW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;

    // cycles since the start edge, modulo the bit period
    logic [PW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ph_q <= '0;
        else if (!busy_o)                    ph_q <= '0;
        else if (ph_q == PW'(CLK_PER_BIT-1)) ph_q <= '0;
        else                                 ph_q <= ph_q + PW'(1);
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_n_o |-> !txd_o);

    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ph_q != '0) |-> $stable(txd_o));

    p_end_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (ph_q == '0));

    p_first_bit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !txd_o);

    p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr_o) < MAX_BYTES);
endmodule

bind rpkt_framer rpf_checker #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .MAX_BYTES   (MAX_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_addr_o (rd_addr_o),
    .busy_o    (busy_o),
    .tx_en_n_o (tx_en_n_o),
    .txd_o     (txd_o)
);

// File: tb/rpkt_framer_tb.sv
`timescale 1ns/1ps
module rpkt_framer_tb;
    localparam int CPB = 4;
    localparam int MAXB = 60;
    localparam int HS = 4;
    localparam int AW = $clog2(MAXB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    pre = 8'd1;
    logic [7:0]    wake = 8'd0;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;
    logic          busy, tx_en_n, txd;
    logic [7:0]    mem [64];

    int nchk = 0;
    int nfail = 0;
    bit expb [8192];
    int nexp;

    always #10 clk = ~clk;

    assign rd_data = mem[rd_addr];

    rpkt_framer #(.CLK_PER_BIT(CPB), .MAX_BYTES(MAXB), .HOLD_SPAN(HS)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .pre_cycles_i (pre),
        .wake_units_i (wake),
        .rd_data_i    (rd_data),
        .rd_addr_o    (rd_addr),
        .busy_o       (busy),
        .tx_en_n_o    (tx_en_n),
        .txd_o        (txd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_nib(input int k);
        int seen = 0;
        logic [5:0] r = '0;
        for (int v = 0; v < 64; v++)
            if ($countones(6'(v)) == 3 && v != 7 && v != 56) begin
                if (seen == k) r = 6'(v);
                seen++;
            end
        return r;
    endfunction

    function automatic logic [11:0] ref_sym(input logic [7:0] b);
        return {ref_nib(int'(b[7:4])), ref_nib(int'(b[3:0]))};
    endfunction

    task automatic push(input logic [11:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            expb[nexp] = w[i];
            nexp++;
        end
    endtask

    task automatic build(input int p, input int wk);
        int n, pe;
        logic [7:0] s;
        nexp = 0;
        n = int'(mem[0][5:0]);
        if (n == 0) n = 1;
        if (n > MAXB) n = MAXB;
        pe = (p == 0) ? 1 : p;
        for (int u = 0; u < wk; u++) begin
            for (int c = 0; c < HS; c++) push(12'b01, 2);
            push(12'h01B, 8);
        end
        for (int c = 0; c < pe; c++) push(12'b01, 2);
        push(12'h0E4, 8);
        s = 8'd0;
        for (int i = 0; i < n; i++) begin
            push(ref_sym(mem[i]), 12);
            s = s + mem[i];
        end
        push(ref_sym(s), 12);
    endtask

    // sends one frame and compares it bit by bit; inj >= 0 pulses start at that bit
    task automatic run_frame(input int p, input int wk, input int inj, input string tag);
        int bad = 0, badbusy = 0, first = -1;
        build(p, wk);
        pre = 8'(p);
        wake = 8'(wk);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < nexp; k++) begin
            repeat (CPB / 2) @(negedge clk);
            if (txd !== expb[k]) begin
                bad++;
                if (first < 0) first = k;
            end
            if (busy !== 1'b1 || tx_en_n !== 1'b0) badbusy++;
            if (k == inj) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                repeat (CPB - CPB / 2 - 1) @(negedge clk);
            end else begin
                repeat (CPB - CPB / 2) @(negedge clk);
            end
        end
        chk(bad == 0, {tag, " frame bits mismatched (first index in msg)"}, bad, 0);
        if (bad != 0) $display("  first mismatch at bit %0d", first);
        chk(badbusy == 0, "R2 busy/enable held during frame", badbusy, 0);
        chk(busy == 1'b0 && tx_en_n == 1'b1 && txd == 1'b0, "R1 idle after frame",
            int'({busy, tx_en_n, txd}), 3'b010);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0 && tx_en_n == 1'b1 && txd == 1'b0, "R1 reset state",
            int'({busy, tx_en_n, txd}), 3'b010);
        chk(rd_addr == '0, "R7 reset address", int'(rd_addr), 0);
    endtask

    task automatic t_symbol_props;
        int badbal = 0, badrun = 0, baddist = 0;
        logic [11:0] a, b;
        for (int x = 0; x < 256; x++) begin
            int run = 1;
            a = ref_sym(8'(x));
            if ($countones(a) != 6) badbal++;
            for (int i = 10; i >= 0; i--) begin
                run = (a[i] == a[i+1]) ? run + 1 : 1;
                if (run > 4) badrun++;
            end
            for (int y = x + 1; y < 256; y++) begin
                b = ref_sym(8'(y));
                if ($countones(a ^ b) < 2) baddist++;
            end
        end
        chk(badbal == 0, "R6 symbol balance", badbal, 0);
        chk(badrun == 0, "R6 symbol run length", badrun, 0);
        chk(baddist == 0, "R6 symbol distance", baddist, 0);
    endtask

    task automatic t_short;
        mem[0] = 8'h01;
        run_frame(1, 0, -1, "R4 R5 R8 one-byte");
    endtask

    task automatic t_medium;
        mem[0] = 8'h05; mem[1] = 8'hA5; mem[2] = 8'h00; mem[3] = 8'hFF; mem[4] = 8'h3C;
        run_frame(3, 0, -1, "R6 R8 five-byte");
    endtask

    task automatic t_wake;
        mem[0] = 8'h03; mem[1] = 8'h77; mem[2] = 8'h81;
        run_frame(2, 2, -1, "R9 wake two units");
        run_frame(1, 1, -1, "R9 wake one unit");
    endtask

    task automatic t_pre_zero;
        mem[0] = 8'h02; mem[1] = 8'h10;
        run_frame(0, 0, -1, "R4 preamble zero as one");
    endtask

    task automatic t_pre_max;
        mem[0] = 8'h02; mem[1] = 8'hEE;
        run_frame(255, 0, -1, "R4 preamble 255");
    endtask

    task automatic t_len_clamp;
        mem[0] = 8'hC0;
        run_frame(1, 0, -1, "R7 control length 0");
        mem[0] = 8'h3F;
        for (int i = 1; i < 64; i++) mem[i] = 8'(i * 7);
        run_frame(1, 0, -1, "R7 control length 63 clamp");
    endtask

    task automatic t_start_busy;
        mem[0] = 8'h04; mem[1] = 8'h12; mem[2] = 8'h34; mem[3] = 8'h56;
        run_frame(2, 0, 20, "R2 start while busy ignored");
    endtask

    task automatic t_all_values;
        for (int p = 0; p < 5; p++) begin
            mem[0] = 8'd60;
            for (int i = 1; i < 60; i++) mem[i] = 8'((p * 59 + i - 1) % 256);
            run_frame(1, 0, -1, "R6 R8 all byte values");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_symbol_props;
        t_short;
        t_medium;
        t_wake;
        t_pre_zero;
        t_pre_max;
        t_len_clamp;
        t_start_busy;
        t_all_values;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule